// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This unit sits on the processor side of the interrupt path. At each instruction boundary it looks at three things: a pending synchronous exception, the request line from the interrupt controller, and the vector the controller returns for the current mask level. It then chooses one of three outcomes: enter the exception, enter the interrupt, or do nothing. When it enters, it computes the complete register update for the entry in a single clock cycle. That update covers the new status word and the new program counter. It also covers the saved copies of the status word, the program counter and the stack register, and the two event-code registers.

Exceptions always outrank interrupts. While the status word's block bit is set, interrupts are held off. In that state an exception turns into a reset entry, unless it carries the one code that is allowed through. Entry addresses come from fixed offsets above the vector base register, or from a fixed reset address. The interrupt mask field of the current status word is passed straight to the interrupt controller so that it can answer the vector query.

Top module: `exc_entry_seq`

## Requirements
- R1: At a boundary (`boundary_i`=1) with `exc_valid_i`=1, the exception is taken whatever the interrupt inputs say. `exc_ack_o` is 1 in that same cycle and `intevt_o` keeps its value.
- R2: While SR bit 28 (block) is 1, an interrupt request is not taken: `take_o` stays 0 and no output register changes.
- R3: While SR bit 28 is 1, an exception with any code other than 0x1E0 is entered as code 0x000 (reset entry). Code 0x1E0 keeps its own code and branches to VBR+0x100.
- R4: With no exception, an interrupt whose `irq_vec_valid_i` is 0 is not taken.
- R5: On any entry, `ssr_o`, `spc_o` and `sgr_o` receive SR, PC and R15, and `sr_o` is SR with bits 28, 29 and 30 set.
- R6: For entry codes 0x000, 0x020 and 0x140, `sr_o` also has bit 15 cleared and bits 7:4 set to 0xF, and `pc_o` is 0xA0000000.
- R7: Codes 0x040 and 0x060 branch to VBR+0x400.
- R8: Code 0x160 branches to VBR+0x100 with `spc_o` = PC+2. Every other code not named in R6 or R7 branches to VBR+0x100 with `spc_o` = PC.
- R9: Every exception entry writes its entry code (after R3) into `expevt_o`.
- R10: An interrupt entry writes `irq_vec_i` into `intevt_o`, branches to VBR+0x600 and leaves `expevt_o` unchanged.
- R11: `irq_mask_o` always equals SR bits 7:4.
- R12: After reset every output register is 0. The entry update appears on the clock edge that samples the boundary, with `take_o` high for exactly that one following cycle. Without an entry, all output registers hold their values, and with `boundary_i`=0 nothing is taken or acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary_i | input | 1 | Instruction boundary, decision cycle |
| exc_valid_i | input | 1 | An exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_req_i | input | 1 | Request from the interrupt controller |
| irq_vec_valid_i | input | 1 | Controller returned a vector for the current mask |
| irq_vec_i | input | 12 | Vector returned by the controller |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current stack register |
| vbr_i | input | 32 | Vector base register |
| irq_mask_o | output | 4 | Mask level given to the controller's vector query |
| exc_ack_o | output | 1 | Pending exception consumed this cycle |
| take_o | output | 1 | Entry update applied, one cycle |
| sr_o | output | 32 | Status word after entry |
| pc_o | output | 32 | Program counter after entry |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack register |
| expevt_o | output | 12 | Exception event code |
| intevt_o | output | 12 | Interrupt event code |

## Verification
The bench builds the block with its default parameters: 32-bit registers, 12-bit event codes, the reset address 0xA0000000, the offsets 0x100, 0x400 and 0x600, and a trap adjustment of 2. With these values every entry-code class can be reached: the three reset-class codes, both codes that go to VBR+0x400, the trap, a general code, and both behaviours of the block bit. The VBR and PC values are chosen so that the offset sums and the +2 adjustment show up as distinct address bits.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 32;
  localparam int EVW  = 12;
  localparam int IMW  = 4;

  // status word field positions
  localparam int SR_BL   = 28;
  localparam int SR_RB   = 29;
  localparam int SR_MD   = 30;
  localparam int SR_FD   = 15;
  localparam int SR_IMLO = 4;

  // entry codes with special handling
  localparam logic [EVW-1:0] EC_RST_A  = 12'h000;
  localparam logic [EVW-1:0] EC_RST_B  = 12'h020;
  localparam logic [EVW-1:0] EC_RST_C  = 12'h140;
  localparam logic [EVW-1:0] EC_TLB_A  = 12'h040;
  localparam logic [EVW-1:0] EC_TLB_B  = 12'h060;
  localparam logic [EVW-1:0] EC_TRAP   = 12'h160;
  localparam logic [EVW-1:0] EC_PASSBL = 12'h1E0;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_EXC  = 2'd1,
    K_IRQ  = 2'd2
  } kind_e;

  function automatic logic is_reset_class(input logic [EVW-1:0] c);
    return (c == EC_RST_A) || (c == EC_RST_B) || (c == EC_RST_C);
  endfunction

  function automatic logic is_tlb_class(input logic [EVW-1:0] c);
    return (c == EC_TLB_A) || (c == EC_TLB_B);
  endfunction

  function automatic logic [XLEN-1:0] entry_sr(input logic [XLEN-1:0] sr,
                                                input logic rst_class);
    logic [XLEN-1:0] s;
    s = sr;
    s[SR_BL] = 1'b1;
    s[SR_MD] = 1'b1;
    s[SR_RB] = 1'b1;
    if (rst_class) begin
      s[SR_FD] = 1'b0;
      s[SR_IMLO +: IMW] = '1;
    end
    return s;
  endfunction
endpackage

// File: rtl/exc_entry_arbiter.sv
module exc_entry_arbiter
  import exc_entry_pkg::*;
(
  input  logic           boundary_i,
  input  logic           exc_valid_i,
  input  logic [EVW-1:0] exc_code_i,
  input  logic           irq_req_i,
  input  logic           irq_vec_valid_i,
  input  logic           blocked_i,
  output kind_e          kind_o,
  output logic [EVW-1:0] code_o,
  output logic           exc_ack_o
);
  logic want_exc;
  logic want_irq;
  logic demote;

  assign want_exc = boundary_i && exc_valid_i;
  assign want_irq = boundary_i && !exc_valid_i && irq_req_i && irq_vec_valid_i && !blocked_i;
  assign demote   = blocked_i && (exc_code_i != EC_PASSBL);

  always_comb begin
    kind_o = K_NONE;
    if (want_exc)      kind_o = K_EXC;
    else if (want_irq) kind_o = K_IRQ;
  end

  assign code_o    = demote ? EC_RST_A : exc_code_i;
  assign exc_ack_o = want_exc;
endmodule

// File: rtl/exc_entry_target.sv
module exc_entry_target
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
  parameter logic [XLEN-1:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [XLEN-1:0] OFS_TLB  = 32'h0000_0400,
  parameter logic [XLEN-1:0] OFS_IRQ  = 32'h0000_0600,
  parameter logic [XLEN-1:0] TRAP_ADJ = 32'd2
) (
  input  kind_e           kind_i,
  input  logic [EVW-1:0]  code_i,
  input  logic [XLEN-1:0] sr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] vbr_i,
  output logic [XLEN-1:0] nsr_o,
  output logic [XLEN-1:0] npc_o,
  output logic [XLEN-1:0] nspc_o
);
  logic is_exc;
  logic rst_entry;
  logic trap_entry;

  assign is_exc     = (kind_i == K_EXC);
  assign rst_entry  = is_exc && is_reset_class(code_i);
  assign trap_entry = is_exc && (code_i == EC_TRAP);

  always_comb begin
    nsr_o  = entry_sr(sr_i, rst_entry);
    nspc_o = trap_entry ? (pc_i + TRAP_ADJ) : pc_i;
    if (kind_i == K_IRQ)            npc_o = vbr_i + OFS_IRQ;
    else if (rst_entry)             npc_o = RESET_PC;
    else if (is_tlb_class(code_i))  npc_o = vbr_i + OFS_TLB;
    else                            npc_o = vbr_i + OFS_GEN;
  end
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
  import exc_entry_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  kind_e           kind_i,
  input  logic [EVW-1:0]  code_i,
  input  logic [EVW-1:0]  vec_i,
  input  logic [XLEN-1:0] sr_i,
  input  logic [XLEN-1:0] r15_i,
  input  logic [XLEN-1:0] nsr_i,
  input  logic [XLEN-1:0] npc_i,
  input  logic [XLEN-1:0] nspc_i,
  output logic            take_o,
  output logic [XLEN-1:0] sr_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] ssr_o,
  output logic [XLEN-1:0] spc_o,
  output logic [XLEN-1:0] sgr_o,
  output logic [EVW-1:0]  expevt_o,
  output logic [EVW-1:0]  intevt_o
);
  logic load;
  logic load_exc;
  logic load_irq;

  assign load_exc = (kind_i == K_EXC);
  assign load_irq = (kind_i == K_IRQ);
  assign load     = load_exc || load_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o   <= 1'b0;
      sr_o     <= '0;
      pc_o     <= '0;
      ssr_o    <= '0;
      spc_o    <= '0;
      sgr_o    <= '0;
      expevt_o <= '0;
      intevt_o <= '0;
    end else begin
      take_o <= load;
      if (load) begin
        sr_o  <= nsr_i;
        pc_o  <= npc_i;
        ssr_o <= sr_i;
        spc_o <= nspc_i;
        sgr_o <= r15_i;
      end
      if (load_exc) expevt_o <= code_i;
      if (load_irq) intevt_o <= vec_i;
    end
  end

  AST_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (sr_o[SR_BL] && sr_o[SR_MD] && sr_o[SR_RB])); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_NONE) |=> ($stable(pc_o) && $stable(expevt_o) && $stable(intevt_o) && !take_o)); // R12

  AST_IRQ_KEEPS_EXPEVT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_IRQ) |=> $stable(expevt_o)); // R10
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
  parameter logic [XLEN-1:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [XLEN-1:0] OFS_TLB  = 32'h0000_0400,
  parameter logic [XLEN-1:0] OFS_IRQ  = 32'h0000_0600,
  parameter logic [XLEN-1:0] TRAP_ADJ = 32'd2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary_i,
  input  logic            exc_valid_i,
  input  logic [EVW-1:0]  exc_code_i,
  input  logic            irq_req_i,
  input  logic            irq_vec_valid_i,
  input  logic [EVW-1:0]  irq_vec_i,
  input  logic [XLEN-1:0] sr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] r15_i,
  input  logic [XLEN-1:0] vbr_i,
  output logic [IMW-1:0]  irq_mask_o,
  output logic            exc_ack_o,
  output logic            take_o,
  output logic [XLEN-1:0] sr_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] ssr_o,
  output logic [XLEN-1:0] spc_o,
  output logic [XLEN-1:0] sgr_o,
  output logic [EVW-1:0]  expevt_o,
  output logic [EVW-1:0]  intevt_o
);
  kind_e           sel_kind;
  logic [EVW-1:0]  entry_code;
  logic [XLEN-1:0] nsr;
  logic [XLEN-1:0] npc;
  logic [XLEN-1:0] nspc;

  assign irq_mask_o = sr_i[SR_IMLO +: IMW];

  exc_entry_arbiter u_arb (
    .boundary_i      (boundary_i),
    .exc_valid_i     (exc_valid_i),
    .exc_code_i      (exc_code_i),
    .irq_req_i       (irq_req_i),
    .irq_vec_valid_i (irq_vec_valid_i),
    .blocked_i       (sr_i[SR_BL]),
    .kind_o          (sel_kind),
    .code_o          (entry_code),
    .exc_ack_o       (exc_ack_o)
  );

  exc_entry_target #(
    .RESET_PC (RESET_PC),
    .OFS_GEN  (OFS_GEN),
    .OFS_TLB  (OFS_TLB),
    .OFS_IRQ  (OFS_IRQ),
    .TRAP_ADJ (TRAP_ADJ)
  ) u_tgt (
    .kind_i (sel_kind),
    .code_i (entry_code),
    .sr_i   (sr_i),
    .pc_i   (pc_i),
    .vbr_i  (vbr_i),
    .nsr_o  (nsr),
    .npc_o  (npc),
    .nspc_o (nspc)
  );

  exc_entry_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind_i   (sel_kind),
    .code_i   (entry_code),
    .vec_i    (irq_vec_i),
    .sr_i     (sr_i),
    .r15_i    (r15_i),
    .nsr_i    (nsr),
    .npc_i    (npc),
    .nspc_i   (nspc),
    .take_o   (take_o),
    .sr_o     (sr_o),
    .pc_o     (pc_o),
    .ssr_o    (ssr_o),
    .spc_o    (spc_o),
    .sgr_o    (sgr_o),
    .expevt_o (expevt_o),
    .intevt_o (intevt_o)
  );

  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && exc_valid_i) |=> (take_o && $stable(intevt_o))); // R1

  AST_BLOCKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !exc_valid_i && sr_i[SR_BL]) |=> !take_o); // R2

  AST_DEMOTE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && exc_valid_i && sr_i[SR_BL] && (exc_code_i != EC_PASSBL))
      |=> ((expevt_o == EC_RST_A) && (pc_o == RESET_PC))); // R3

  AST_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !exc_valid_i && !irq_vec_valid_i) |=> !take_o); // R4
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 1'b0;
  logic        exc_valid_i = 1'b0;
  logic [11:0] exc_code_i = '0;
  logic        irq_req_i = 1'b0;
  logic        irq_vec_valid_i = 1'b0;
  logic [11:0] irq_vec_i = '0;
  logic [31:0] sr_i = '0, pc_i = '0, r15_i = '0, vbr_i = '0;
  logic [3:0]  irq_mask_o;
  logic        exc_ack_o, take_o;
  logic [31:0] sr_o, pc_o, ssr_o, spc_o, sgr_o;
  logic [11:0] expevt_o, intevt_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .exc_valid_i(exc_valid_i),
    .exc_code_i(exc_code_i), .irq_req_i(irq_req_i), .irq_vec_valid_i(irq_vec_valid_i),
    .irq_vec_i(irq_vec_i), .sr_i(sr_i), .pc_i(pc_i), .r15_i(r15_i), .vbr_i(vbr_i),
    .irq_mask_o(irq_mask_o), .exc_ack_o(exc_ack_o), .take_o(take_o), .sr_o(sr_o),
    .pc_o(pc_o), .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o),
    .expevt_o(expevt_o), .intevt_o(intevt_o)
  );

  typedef struct packed {
    logic        ev;
    logic [11:0] code;
    logic        irq;
    logic        vv;
    logic [11:0] vec;
    logic [31:0] sr;
    logic [31:0] pc;
    logic [31:0] vbr;
  } stim_t;

  localparam int NROW = 14;
  localparam stim_t TBL [NROW] = '{
    '{1'b1, 12'h160, 1'b1, 1'b1, 12'h200, 32'h0000_80A0, 32'h8C00_1000, 32'h8C00_0000}, // R1 R8 R5 R9
    '{1'b1, 12'h040, 1'b0, 1'b0, 12'h000, 32'h0000_0050, 32'h8C00_2004, 32'h8C01_0000}, // R7
    '{1'b1, 12'h060, 1'b0, 1'b0, 12'h000, 32'h4000_0010, 32'h8C00_2008, 32'h8C02_0000}, // R7
    '{1'b1, 12'h140, 1'b0, 1'b0, 12'h000, 32'h0000_8030, 32'h8C00_3000, 32'h8C00_0000}, // R6
    '{1'b1, 12'h020, 1'b1, 1'b1, 12'h100, 32'h0000_8000, 32'h8C00_3010, 32'h8C00_0000}, // R6
    '{1'b1, 12'h000, 1'b0, 1'b0, 12'h000, 32'h2000_80C0, 32'h8C00_3020, 32'h8C00_0000}, // R6
    '{1'b1, 12'h1A0, 1'b0, 1'b0, 12'h000, 32'h0000_0070, 32'h8C00_4000, 32'h8C03_0000}, // R8
    '{1'b1, 12'h0E0, 1'b0, 1'b0, 12'h000, 32'h1000_80A0, 32'h8C00_5000, 32'h8C00_0000}, // R3
    '{1'b1, 12'h1E0, 1'b0, 1'b0, 12'h000, 32'h1000_80A0, 32'h8C00_5004, 32'h8C04_0000}, // R3
    '{1'b0, 12'h000, 1'b1, 1'b1, 12'h200, 32'h0000_0030, 32'h8C00_6000, 32'h8C05_0000}, // R10
    '{1'b0, 12'h000, 1'b1, 1'b1, 12'h220, 32'h1000_0030, 32'h8C00_6004, 32'h8C05_0000}, // R2
    '{1'b0, 12'h000, 1'b1, 1'b0, 12'h240, 32'h0000_0030, 32'h8C00_6008, 32'h8C05_0000}, // R4
    '{1'b0, 12'h000, 1'b0, 1'b0, 12'h000, 32'h0000_0000, 32'h8C00_600C, 32'h8C05_0000}, // R12
    '{1'b0, 12'h000, 1'b1, 1'b1, 12'h3C0, 32'h0000_8090, 32'h8C00_7000, 32'h8C06_0000}  // R10
  };

  logic        e_take, e_ack;
  logic [31:0] e_sr = '0, e_pc = '0, e_ssr = '0, e_spc = '0, e_sgr = '0;
  logic [11:0] e_exp = '0, e_int = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected result written from the requirement list
  task automatic predict(input stim_t s);
    logic [11:0] c;
    logic        bl;
    bl = s.sr[28];
    e_ack = s.ev;
    e_take = 1'b0;
    if (s.ev) begin
      e_take = 1'b1;
      c = (bl && s.code != 12'h1E0) ? 12'h000 : s.code;
      e_ssr = s.sr; e_sgr = s.pc ^ 32'h5555_0000; e_spc = s.pc;
      e_sr = s.sr | 32'h7000_0000;
      e_exp = c;
      if (c == 12'h000 || c == 12'h020 || c == 12'h140) begin
        e_sr = (e_sr & ~32'h0000_8000) | 32'h0000_00F0;
        e_pc = 32'hA000_0000;
      end else if (c == 12'h040 || c == 12'h060) begin
        e_pc = s.vbr + 32'h400;
      end else begin
        if (c == 12'h160) e_spc = s.pc + 32'd2;
        e_pc = s.vbr + 32'h100;
      end
    end else if (s.irq && s.vv && !bl) begin
      e_take = 1'b1;
      e_ssr = s.sr; e_sgr = s.pc ^ 32'h5555_0000; e_spc = s.pc;
      e_sr = s.sr | 32'h7000_0000;
      e_int = s.vec;
      e_pc = s.vbr + 32'h600;
    end
  endtask

  task automatic apply(input stim_t s);
    exc_valid_i = s.ev; exc_code_i = s.code; irq_req_i = s.irq;
    irq_vec_valid_i = s.vv; irq_vec_i = s.vec; sr_i = s.sr; pc_i = s.pc;
    r15_i = s.pc ^ 32'h5555_0000; vbr_i = s.vbr; boundary_i = 1'b1;
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " take"}, {31'd0, take_o}, {31'd0, e_take});
    chk({tag, " sr"}, sr_o, e_sr);
    chk({tag, " pc"}, pc_o, e_pc);
    chk({tag, " ssr"}, ssr_o, e_ssr);
    chk({tag, " spc"}, spc_o, e_spc);
    chk({tag, " sgr"}, sgr_o, e_sgr);
    chk({tag, " expevt"}, {20'd0, expevt_o}, {20'd0, e_exp});
    chk({tag, " intevt"}, {20'd0, intevt_o}, {20'd0, e_int});
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    e_take = 1'b0;
    check_outputs("R12 reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROW; i++) begin
      apply(TBL[i]);
      predict(TBL[i]);
      #2;
      chk($sformatf("R1 row %0d ack", i), {31'd0, exc_ack_o}, {31'd0, e_ack});
      chk($sformatf("R11 row %0d mask", i), {28'd0, irq_mask_o}, {28'd0, TBL[i].sr[7:4]});
      @(negedge clk);
      boundary_i = 1'b0;
      check_outputs($sformatf("row %0d (R2 R3 R4 R5 R6 R7 R8 R9 R10)", i));
      @(negedge clk);
      chk($sformatf("R12 row %0d take one cycle", i), {31'd0, take_o}, 32'd0);
    end

    // R12: exception pending but no boundary: no ack, no entry
    exc_valid_i = 1'b1; exc_code_i = 12'h040; irq_req_i = 1'b1; irq_vec_valid_i = 1'b1;
    sr_i = 32'h0; boundary_i = 1'b0;
    #2;
    chk("R12 no boundary ack", {31'd0, exc_ack_o}, 32'd0);
    @(negedge clk);
    e_take = 1'b0;
    check_outputs("R12 no boundary");

    // R10 then R1: interrupt event survives a following exception
    apply('{1'b0, 12'h000, 1'b1, 1'b1, 12'h5A0, 32'h0000_00F0, 32'h8C00_8000, 32'h8C07_0000});
    predict('{1'b0, 12'h000, 1'b1, 1'b1, 12'h5A0, 32'h0000_00F0, 32'h8C00_8000, 32'h8C07_0000});
    @(negedge clk);
    check_outputs("R10 directed irq");
    apply('{1'b1, 12'h160, 1'b1, 1'b1, 12'h600, 32'h0000_0000, 32'h8C00_8100, 32'h8C07_0000});
    predict('{1'b1, 12'h160, 1'b1, 1'b1, 12'h600, 32'h0000_0000, 32'h8C00_8100, 32'h8C07_0000});
    @(negedge clk);
    boundary_i = 1'b0;
    check_outputs("R1 back-to-back exception");
    chk("R1 intevt kept", {20'd0, intevt_o}, 32'h0000_05A0);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule